// File: doc/BRIEF.md
# Command Method Macro Trigger Collector

This block sits on the write stream of a graphics command engine. Each write carries a method index, a 32-bit argument and a flag that marks the last word of a burst. Low method indices are register writes and pass straight through to a downstream register port. Indices at or above a fixed boundary (0xE00) are macro triggers. The block collects the argument words of a trigger into a parameter FIFO. When the marked word arrives, it raises a macro-execute request.

The request carries two values. The first is a start address, read from a small bind table indexed by the trigger method. The second is the number of gathered parameters. The consumer drains the parameters through a show-ahead pop port and then accepts the request, which empties the FIFO. Input is held off until that acceptance.

Protocol violations set sticky error flags:
- a macro that starts on an odd index;
- a foreign method in the middle of a collection;
- a FIFO overflow.

A separate port loads the bind table through an auto-incrementing pointer.

Top module: `macro_trigger_collector`

## Requirements
- R1: While no macro is being collected and no request is pending, a write with method below 0xE00 raises reg_valid_o in the same cycle with its method and argument. A write at or above 0xE00 never raises reg_valid_o.
- R2: An accepted even method at or above 0xE00, while idle, starts a collection. Its own argument becomes the first parameter.
- R3: An odd method at or above 0xE00, while idle, sets err_odd_start_o (sticky). The write is dropped, no collection starts and no request follows.
- R4: During a collection, any method other than trigger+1 sets err_bad_method_o (sticky). That write is dropped entirely, including its last flag: it is neither stored nor routed, and the collection goes on.
- R5: The cycle after the accepted write marked last (trigger or argument), exec_valid_o is 1. At that point exec_count_o equals the number of stored parameters.
- R6: exec_addr_o equals bind entry ((trigger − 0xE00) >> 1) mod BIND_ENTRIES, where BIND_ENTRIES is 8 by default.
- R7: While exec_valid_o is 1 and exec_ready_i is 0, cmd_ready_o is 0, no write is taken, and exec_addr_o and exec_count_o hold. The cycle after acceptance, exec_valid_o is 0, the FIFO is empty and cmd_ready_o is 1.
- R8: pop_data_o shows the oldest parameter. pop_i removes it, and parameters leave in arrival order.
- R9: The FIFO holds 32 words. Further words are dropped and set err_overflow_o (sticky), and the count stays at 32.
- R10: bind_wr_i stores bind_data_i at the bind pointer, and the pointer then increments, wrapping from 7 to 0. bind_ptr_ld_i loads the pointer. When both arrive in one cycle, the write goes to the loaded index and the pointer becomes that index + 1.
- R11: After reset:
  - cmd_ready_o is 1, exec_valid_o is 0 and all error flags are 0;
  - pop_empty_o is 1;
  - every bind entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Write present |
| cmd_ready_o | output | 1 | Write taken this cycle when high |
| cmd_method_i | input | 13 | Method index |
| cmd_arg_i | input | 32 | Argument word |
| cmd_last_i | input | 1 | Last word of burst |
| reg_valid_o | output | 1 | Register-port write strobe |
| reg_method_o | output | 13 | Register-port method |
| reg_arg_o | output | 32 | Register-port argument |
| bind_wr_i | input | 1 | Bind table data write |
| bind_data_i | input | 32 | Bind table data |
| bind_ptr_ld_i | input | 1 | Bind pointer load |
| bind_ptr_i | input | 3 | Bind pointer value |
| exec_valid_o | output | 1 | Macro execute request |
| exec_ready_i | input | 1 | Request accepted |
| exec_addr_o | output | 32 | Macro start address |
| exec_count_o | output | 6 | Parameter count |
| pop_i | input | 1 | Remove oldest parameter |
| pop_data_o | output | 32 | Oldest parameter |
| pop_empty_o | output | 1 | FIFO empty |
| err_odd_start_o | output | 1 | Sticky odd-start error |
| err_bad_method_o | output | 1 | Sticky foreign-method error |
| err_overflow_o | output | 1 | Sticky FIFO overflow |

## Verification
The hardest situation to reach is a collection that stays alive after a rejected write. That rejected write carries a method from a foreign trigger or a register index, and it sits between valid argument words. Directed stimulus covers this case. The final parameter list and count must leave the rejected word out.

Overflow needs a single burst longer than the FIFO, and the bench builds one explicitly. Backpressure is exercised by presenting register writes while a request is held unaccepted. Random bursts of random even triggers and lengths cover the bind-index folding across the whole trigger range.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned METHOD_W = 13;
  localparam int unsigned DATA_W   = 32;
  localparam logic [METHOD_W-1:0] MACRO_BASE = 13'hE00;
endpackage

// File: rtl/mtc_param_fifo.sv
module mtc_param_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic push_ok, pop_ok;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign push_ok   = push_i && !full_o;
  assign pop_ok    = pop_i && !empty_o;
  assign head_o    = mem_q[rd_q];
  assign cnt_nxt_o = flush_i ? '0 : cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);

  function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= inc(wr_q);
      if (pop_ok)  rd_q <= inc(rd_q);
      cnt_q <= cnt_nxt_o;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= push_data_i;
  end

  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i && !flush_i) |=> full_o);
  assert_flush_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/mtc_bind_table.sv
module mtc_bind_table #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             ptr_ld_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] ent_q [ENTRIES];
  logic [IDX_W-1:0] ptr_q, wr_idx;

  // pointer load takes effect for a same-cycle write
  assign wr_idx    = ptr_ld_i ? ptr_i : ptr_q;
  assign rd_data_o = ent_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (wr_i) ptr_q <= (wr_idx == IDX_W'(ENTRIES - 1)) ? '0 : wr_idx + IDX_W'(1);
    else if (ptr_ld_i) ptr_q <= ptr_i;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (wr_i && wr_idx == IDX_W'(g)) ent_q[g] <= wr_data_i;
    end
  end

  assert_bind_store_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ptr_ld_i) |=> ent_q[$past(ptr_q)] == $past(wr_data_i));
endmodule

// File: rtl/mtc_sequencer.sv
module mtc_sequencer
  import mtc_pkg::*;
#(
  parameter int unsigned BIND_ENTRIES = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned CNT_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [METHOD_W-1:0] cmd_method_i,
  input  logic                cmd_last_i,
  output logic                cmd_ready_o,
  output logic                reg_valid_o,
  output logic                push_o,
  input  logic                fifo_full_i,
  input  logic [CNT_W-1:0]    fifo_cnt_nxt_i,
  output logic                flush_o,
  output logic [IDX_W-1:0]    bind_idx_o,
  input  logic [DATA_W-1:0]   bind_rd_i,
  output logic                exec_valid_o,
  input  logic                exec_ready_i,
  output logic [DATA_W-1:0]   exec_addr_o,
  output logic [CNT_W-1:0]    exec_count_o,
  output logic                err_odd_o,
  output logic                err_bad_o,
  output logic                err_ovf_o
);
  logic coll_q, exec_valid_q, err_odd_q, err_bad_q, err_ovf_q;
  logic [METHOD_W-1:0] trig_q, cur_trig, trig_off;
  logic [DATA_W-1:0]   exec_addr_q;
  logic [CNT_W-1:0]    exec_cnt_q;
  logic acc, is_macro, arg_match, start_ok, odd_start, arg_ok, bad_arg, take, fire;

  assign acc       = cmd_valid_i && !exec_valid_q;
  assign is_macro  = cmd_method_i >= MACRO_BASE;
  assign arg_match = cmd_method_i == trig_q + METHOD_W'(1);
  assign start_ok  = acc && !coll_q && is_macro && !cmd_method_i[0];
  assign odd_start = acc && !coll_q && is_macro && cmd_method_i[0];
  assign arg_ok    = acc && coll_q && arg_match;
  assign bad_arg   = acc && coll_q && !arg_match;
  assign take      = start_ok || arg_ok;
  assign fire      = take && cmd_last_i;

  assign cmd_ready_o = !exec_valid_q;
  assign reg_valid_o = acc && !coll_q && !is_macro;
  assign push_o      = take && !fifo_full_i;
  assign flush_o     = exec_valid_q && exec_ready_i;

  // bind index of the trigger being fired
  assign cur_trig   = coll_q ? trig_q : cmd_method_i;
  assign trig_off   = (cur_trig - MACRO_BASE) >> 1;
  assign bind_idx_o = IDX_W'(trig_off % METHOD_W'(BIND_ENTRIES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q       <= 1'b0;
      trig_q       <= '0;
      exec_valid_q <= 1'b0;
      exec_addr_q  <= '0;
      exec_cnt_q   <= '0;
      err_odd_q    <= 1'b0;
      err_bad_q    <= 1'b0;
      err_ovf_q    <= 1'b0;
    end else begin
      if (start_ok && !cmd_last_i) begin
        coll_q <= 1'b1;
        trig_q <= cmd_method_i;
      end
      if (fire) begin
        coll_q       <= 1'b0;
        exec_valid_q <= 1'b1;
        exec_addr_q  <= bind_rd_i;
        exec_cnt_q   <= fifo_cnt_nxt_i;
      end else if (flush_o) begin
        exec_valid_q <= 1'b0;
      end
      if (odd_start) err_odd_q <= 1'b1;
      if (bad_arg) err_bad_q <= 1'b1;
      if (take && fifo_full_i) err_ovf_q <= 1'b1;
    end
  end

  assign exec_valid_o = exec_valid_q;
  assign exec_addr_o  = exec_addr_q;
  assign exec_count_o = exec_cnt_q;
  assign err_odd_o    = err_odd_q;
  assign err_bad_o    = err_bad_q;
  assign err_ovf_o    = err_ovf_q;

  assert_reg_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_o |-> (cmd_method_i < MACRO_BASE) && !exec_valid_o);
  assert_odd_no_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_start |=> err_odd_o && !coll_q && !exec_valid_o);
  assert_bad_no_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_arg |-> !push_o && !reg_valid_o);
  assert_fire_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> exec_valid_o);
  assert_exec_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !exec_ready_i) |=> exec_valid_o && $stable(exec_addr_o) && $stable(exec_count_o));
  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> !push_o && !reg_valid_o);
endmodule

// File: rtl/macro_trigger_collector.sv
module macro_trigger_collector
  import mtc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH   = 32,
  parameter int unsigned BIND_ENTRIES = 8,
  localparam int unsigned IDX_W = (BIND_ENTRIES > 1) ? $clog2(BIND_ENTRIES) : 1,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic [METHOD_W-1:0] cmd_method_i,
  input  logic [DATA_W-1:0]   cmd_arg_i,
  input  logic                cmd_last_i,
  output logic                reg_valid_o,
  output logic [METHOD_W-1:0] reg_method_o,
  output logic [DATA_W-1:0]   reg_arg_o,
  input  logic                bind_wr_i,
  input  logic [DATA_W-1:0]   bind_data_i,
  input  logic                bind_ptr_ld_i,
  input  logic [IDX_W-1:0]    bind_ptr_i,
  output logic                exec_valid_o,
  input  logic                exec_ready_i,
  output logic [DATA_W-1:0]   exec_addr_o,
  output logic [CNT_W-1:0]    exec_count_o,
  input  logic                pop_i,
  output logic [DATA_W-1:0]   pop_data_o,
  output logic                pop_empty_o,
  output logic                err_odd_start_o,
  output logic                err_bad_method_o,
  output logic                err_overflow_o
);
  logic             push, flush, fifo_full;
  logic [CNT_W-1:0] cnt_nxt;
  logic [IDX_W-1:0] bind_idx;
  logic [DATA_W-1:0] bind_rd;

  assign reg_method_o = cmd_method_i;
  assign reg_arg_o    = cmd_arg_i;

  mtc_sequencer #(
    .BIND_ENTRIES(BIND_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_method_i, .cmd_last_i, .cmd_ready_o,
    .reg_valid_o, .push_o(push), .fifo_full_i(fifo_full), .fifo_cnt_nxt_i(cnt_nxt),
    .flush_o(flush), .bind_idx_o(bind_idx), .bind_rd_i(bind_rd),
    .exec_valid_o, .exec_ready_i, .exec_addr_o, .exec_count_o,
    .err_odd_o(err_odd_start_o), .err_bad_o(err_bad_method_o), .err_ovf_o(err_overflow_o)
  );

  mtc_param_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i, .rst_ni, .push_i(push), .push_data_i(cmd_arg_i), .pop_i, .flush_i(flush),
    .head_o(pop_data_o), .empty_o(pop_empty_o), .full_o(fifo_full), .cnt_nxt_o(cnt_nxt)
  );

  mtc_bind_table #(.WIDTH(DATA_W), .ENTRIES(BIND_ENTRIES)) i_bind (
    .clk_i, .rst_ni, .wr_i(bind_wr_i), .wr_data_i(bind_data_i), .ptr_ld_i(bind_ptr_ld_i),
    .ptr_i(bind_ptr_i), .rd_idx_i(bind_idx), .rd_data_o(bind_rd)
  );
endmodule

// File: tb/test_macro_trigger_collector.sv
module test_macro_trigger_collector;
  logic clk = 0, rst_ni = 0;
  logic cmd_valid_i = 0, cmd_last_i = 0, cmd_ready_o;
  logic [12:0] cmd_method_i = '0;
  logic [31:0] cmd_arg_i = '0;
  logic reg_valid_o;
  logic [12:0] reg_method_o;
  logic [31:0] reg_arg_o;
  logic bind_wr_i = 0, bind_ptr_ld_i = 0;
  logic [31:0] bind_data_i = '0;
  logic [2:0] bind_ptr_i = '0;
  logic exec_valid_o, exec_ready_i = 0;
  logic [31:0] exec_addr_o;
  logic [5:0] exec_count_o;
  logic pop_i = 0, pop_empty_o;
  logic [31:0] pop_data_o;
  logic err_odd_start_o, err_bad_method_o, err_overflow_o;

  always #5 clk = ~clk;

  macro_trigger_collector i_macro_trigger_collector (.clk_i(clk), .*);

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] bind_m [8];
  int bptr = 0;
  bit mcoll = 0, fire_pend = 0, e_odd = 0, e_bad = 0, e_ovf = 0;
  logic [12:0] mtrig;
  logic [31:0] e_addr;
  logic [31:0] q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bidx(input logic [12:0] m);
    return ((int'(m) - 'hE00) >> 1) % 8;
  endfunction

  task automatic mpush(input logic [31:0] a);
    if (q.size() < 32) q.push_back(a);
    else e_ovf = 1;
  endtask

  task automatic send(input logic [12:0] m, input logic [31:0] a, input bit l);
    bit exp_reg = 0;
    if (!mcoll) begin
      if (m < 13'hE00) exp_reg = 1;
      else if (m[0]) e_odd = 1;
      else begin
        mpush(a);
        if (l) begin fire_pend = 1; e_addr = bind_m[bidx(m)]; end
        else begin mcoll = 1; mtrig = m; end
      end
    end else if (m == mtrig + 13'd1) begin
      mpush(a);
      if (l) begin fire_pend = 1; mcoll = 0; e_addr = bind_m[bidx(mtrig)]; end
    end else e_bad = 1;
    @(negedge clk);
    cmd_valid_i = 1; cmd_method_i = m; cmd_arg_i = a; cmd_last_i = l;
    #1;
    chk(reg_valid_o == exp_reg, "R1 reg_valid", reg_valid_o, exp_reg);
    if (exp_reg) chk(reg_method_o == m && reg_arg_o == a, "R1 reg data", reg_arg_o, a);
    @(posedge clk); #1;
    cmd_valid_i = 0; cmd_last_i = 0;
  endtask

  task automatic bind_op(input bit wr, input bit ld, input int p, input logic [31:0] d);
    @(negedge clk);
    bind_wr_i = wr; bind_ptr_ld_i = ld; bind_ptr_i = 3'(p); bind_data_i = d;
    @(posedge clk); #1;
    bind_wr_i = 0; bind_ptr_ld_i = 0;
    if (ld) bptr = p;
    if (wr) begin bind_m[bptr] = d; bptr = (bptr + 1) % 8; end
  endtask

  task automatic check_errs();
    @(negedge clk);
    chk(err_odd_start_o == e_odd, "R3 err_odd", err_odd_start_o, e_odd);
    chk(err_bad_method_o == e_bad, "R4 err_bad", err_bad_method_o, e_bad);
    chk(err_overflow_o == e_ovf, "R9 err_ovf", err_overflow_o, e_ovf);
  endtask

  // check request, pop npop params, hold, then accept
  task automatic drain(input int npop, input int hold);
    @(negedge clk);
    chk(exec_valid_o == 1, "R5 exec_valid", exec_valid_o, 1);
    chk(exec_count_o == 6'(q.size()), "R5 count", exec_count_o, q.size());
    chk(exec_addr_o == e_addr, "R6 addr", exec_addr_o, e_addr);
    chk(cmd_ready_o == 0, "R7 stall", cmd_ready_o, 0);
    for (int i = 0; i < npop && i < q.size(); i++) begin
      pop_i = 1; #1;
      chk(pop_data_o == q[i], i == 0 ? "R2 first param" : "R8 param order", pop_data_o, q[i]);
      @(negedge clk);
    end
    pop_i = 0;
    for (int h = 0; h < hold; h++) begin
      cmd_valid_i = 1; cmd_method_i = 13'h010; cmd_last_i = 0; #1;
      chk(reg_valid_o == 0 && cmd_ready_o == 0, "R7 backpressure", reg_valid_o, 0);
      @(negedge clk);
      chk(exec_valid_o == 1 && exec_addr_o == e_addr, "R7 hold", exec_addr_o, e_addr);
    end
    cmd_valid_i = 0;
    exec_ready_i = 1;
    @(posedge clk); #1;
    exec_ready_i = 0;
    @(negedge clk);
    chk(exec_valid_o == 0, "R7 released", exec_valid_o, 0);
    chk(pop_empty_o == 1, "R7 flushed", pop_empty_o, 1);
    chk(cmd_ready_o == 1, "R7 ready", cmd_ready_o, 1);
    q.delete();
    fire_pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7781));
    for (int i = 0; i < 8; i++) bind_m[i] = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(cmd_ready_o == 1, "R11 ready", cmd_ready_o, 1);
    chk(exec_valid_o == 0, "R11 exec", exec_valid_o, 0);
    chk(pop_empty_o == 1, "R11 empty", pop_empty_o, 1);
    chk({err_odd_start_o, err_bad_method_o, err_overflow_o} == 0, "R11 errors",
        {err_odd_start_o, err_bad_method_o, err_overflow_o}, 0);
    // R11 table zero: single-word macro
    send(13'hE06, 32'hA5A5_0001, 1);
    chk(exec_addr_o == 0, "R11 bind zero", exec_addr_o, 0);
    drain(1, 0);

    // R10 fill table, wrap, load, simultaneous load+write
    for (int i = 0; i < 9; i++) bind_op(1, 0, 0, 32'h1000 + 32'(i));
    bind_op(0, 1, 5, 0);
    bind_op(1, 0, 0, 32'h5555);
    bind_op(1, 1, 2, 32'h2222);
    bind_op(1, 0, 0, 32'h3333);
    for (int k = 0; k < 8; k++) begin
      send(13'hE00 + 13'(2 * k) + 13'h10, 32'(k), 1); // entry (k+8)%8 = k
      chk(exec_addr_o == bind_m[k], "R10 table", exec_addr_o, bind_m[k]);
      drain(1, 0);
    end

    // random bursts with interleaved register writes
    for (int it = 0; it < 60; it++) begin
      int nreg = $urandom_range(0, 2);
      int len = $urandom_range(1, 10);
      logic [12:0] trg = 13'hE00 + 13'(2 * $urandom_range(0, 'h8FF));
      for (int r = 0; r < nreg; r++) send(13'($urandom_range(0, 'hDFF)), $urandom, 0);
      for (int w = 0; w < len; w++)
        send(w == 0 ? trg : trg + 13'd1, $urandom, w == len - 1);
      drain(len, $urandom_range(0, 2));
    end
    check_errs();

    // R3 odd start
    send(13'hE01, 32'hDEAD, 1);
    @(negedge clk);
    chk(exec_valid_o == 0 && pop_empty_o == 1, "R3 no request", exec_valid_o, 0);
    check_errs();
    send(13'hE02, 32'h1, 0); send(13'hE03, 32'h2, 1);
    drain(2, 0);

    // R4 foreign methods mid-collection, including a last-marked one
    send(13'hE10, 32'h11, 0);
    send(13'hE12, 32'h99, 1);
    send(13'h100, 32'h98, 0);
    send(13'hE11, 32'h22, 0);
    send(13'hE11, 32'h33, 1);
    drain(3, 1);
    check_errs();

    // R9 overflow
    for (int w = 0; w < 40; w++) send(w == 0 ? 13'hE20 : 13'hE21, 32'h7000 + 32'(w), w == 39);
    chk(q.size() == 32, "R9 model depth", q.size(), 32);
    drain(5, 0);
    check_errs();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule